// File: doc/BRIEF.md
# Host Bridge I/O Window Translator

This block takes CPU accesses that land in the host bridge's I/O window and reissues them on the PCI I/O side. The CPU side presents an offset into the window, a size in bytes and, for writes, data. The block maps the offset to a 16-bit I/O port address and adds the I/O base back on. It then drives one or two word-aligned downstream transactions with per-byte lane enables. When both halves are done it returns a single response.

A level input picks the address map. When it is low, the block uses plain 64 KB masking. When it is high, it uses a sparse 8 MB map. The sparse map keeps offset bits 4..0, moves offset bits 22..12 down to port bits 15..5 and discards bits 11..5. The block latches the level when it accepts a request. An access that runs past a 4-byte word boundary is cut into two downstream transactions. Read data from the two halves is rejoined in little-endian order.

The controller has four states. IDLE accepts a request: a legal size goes to LO_XFER and any other size goes straight to REPLY with an error. LO_XFER drives the transaction that holds the first byte; on completion it goes to HI_XFER if bytes remain in the next word, otherwise to REPLY. HI_XFER drives the following word and goes to REPLY on completion. REPLY pulses the response for one cycle and returns to IDLE.

Top module: `io_window_xlate`

## Requirements
- R1: After reset the block is in IDLE: req_ready is 1, dn_valid is 0 and rsp_valid is 0.
- R2: With map_sparse low at acceptance, the port address is offset bits 15..0. dn_addr equals BASE (0x8000_0000) plus that port address with bits 1..0 cleared.
- R3: With map_sparse high at acceptance, the port address is {offset[22:12], offset[4:0]}. Offset bits 11..5 have no effect. dn_addr is BASE plus this address with bits 1..0 cleared.
- R4: req_size is a byte count. For sizes 1, 2 and 4, dn_be bit n enables byte lane n (dn_wdata[8n+7:8n]). The enabled lanes start at offset[1:0]. Request data byte i (req_wdata[8i+7:8i]) goes to lane offset[1:0]+i.
- R5: Any req_size other than 1, 2 or 4 gives a response with rsp_err=1 and rsp_rdata=0. No downstream transaction is issued.
- R6: When offset[1:0]+size exceeds 4, the access becomes two transactions. The first goes to the word holding the offset. The second goes to the next word (offset rounded down plus 4), translated on its own, with the remaining bytes starting at lane 0.
- R7: Read response byte i is lane (offset[1:0]+i) mod 4 of the transaction that held that byte. Response bytes at or above the size read as zero.
- R8: The map level is sampled when the request is accepted. A change on map_sparse during a transaction does not alter its addresses.
- R9: dn_valid is held, with address, lanes and direction stable, until dn_ready. req_ready is 0 while a request is in flight. Each accepted request gets exactly one single-cycle rsp_valid pulse.
- R10: A write with a legal size responds with rsp_err=0 and rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_sparse | input | 1 | Map select level: 0 = 64 KB masked, 1 = sparse 8 MB |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Byte offset within the window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, lowest address in bits 7..0 |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Illegal size |
| rsp_rdata | output | 32 | Read data, lowest address in bits 7..0 |
| dn_valid | output | 1 | Downstream transaction present |
| dn_ready | input | 1 | Downstream completes the transaction |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | 32 | Word-aligned downstream address |
| dn_be | output | 4 | Byte lane enables |
| dn_wdata | output | 32 | Lane-aligned write data |
| dn_rdata | input | 32 | Read data, valid with dn_ready |

## Verification
Aligned reads and writes of each legal size are run in both maps. The offsets carry set bits above bit 15 and inside bits 11..5, so a map that keeps the wrong bits shows up as a wrong address. Accesses starting at lanes 1, 2 and 3 with sizes that cross a word are run with a stalling downstream. These separate correct splitting, translation of the second word and byte reassembly from lane or order mistakes. Illegal sizes must produce no downstream traffic at all. One access flips the map level just after acceptance, which distinguishes a latched mode from a live one.

// File: rtl/io_xlate_pkg.sv
package io_xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LO_XFER,
        ST_HI_XFER,
        ST_REPLY
    } xfer_state_e;

    // Legal access sizes are 1, 2 and 4 bytes.
    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/io_addr_map.sv
module io_addr_map #(
    parameter int OFF_W  = 23,
    parameter int KEEP_W = 5,
    parameter int HI_LSB = 12,
    parameter int MAP_W  = KEEP_W + OFF_W - HI_LSB
) (
    input  logic             sparse,
    input  logic [OFF_W-1:0] off,
    output logic [MAP_W-1:0] port
);

    logic [MAP_W-1:0] dense_port;
    logic [MAP_W-1:0] sparse_port;

    assign dense_port  = off[MAP_W-1:0];
    assign sparse_port = {off[OFF_W-1:HI_LSB], off[KEEP_W-1:0]};
    assign port        = sparse ? sparse_port : dense_port;

endmodule

// File: rtl/io_lane_unit.sv
module io_lane_unit #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANE_W-1:0] lane,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_lo,
    input  logic [DATA_W-1:0] rd_hi,
    output logic              split,
    output logic [LANES-1:0]  be_lo,
    output logic [LANES-1:0]  be_hi,
    output logic [DATA_W-1:0] wd_lo,
    output logic [DATA_W-1:0] wd_hi,
    output logic [DATA_W-1:0] rdata
);

    logic [LANES-1:0]    size_mask;
    logic [DATA_W-1:0]   data_mask;
    logic [2*LANES-1:0]  be_wide;
    logic [2*DATA_W-1:0] wd_wide;
    logic [LANE_W+2:0]   bit_shift;

    always_comb begin
        unique case (size)
            3'd1:    size_mask = LANES'(1);
            3'd2:    size_mask = LANES'(3);
            default: size_mask = '1;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_byte_mask
        assign data_mask[8*g +: 8] = {8{size_mask[g]}};
    end

    assign bit_shift = {lane, 3'b000};
    assign be_wide   = {{LANES{1'b0}}, size_mask} << lane;
    assign wd_wide   = {{DATA_W{1'b0}}, wdata & data_mask} << bit_shift;

    assign be_lo = be_wide[LANES-1:0];
    assign be_hi = be_wide[2*LANES-1:LANES];
    assign wd_lo = wd_wide[DATA_W-1:0];
    assign wd_hi = wd_wide[2*DATA_W-1:DATA_W];
    assign split = |be_hi;

    assign rdata = DATA_W'({rd_hi, rd_lo} >> bit_shift) & data_mask;

endmodule

// File: rtl/io_window_xlate.sv
module io_window_xlate
    import io_xlate_pkg::*;
#(
    parameter int          OFF_W  = 23,
    parameter int          DATA_W = 32,
    parameter int          ADDR_W = 32,
    parameter logic [31:0] BASE   = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sparse,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [OFF_W-1:0]  req_addr,
    input  logic [2:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W/8-1:0] dn_be,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata
);

    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int MAP_W  = 5 + OFF_W - 12;

    xfer_state_e state, state_nx;

    logic              r_write;
    logic              r_sparse;
    logic              r_err;
    logic [OFF_W-1:0]  r_off;
    logic [2:0]        r_size;
    logic [DATA_W-1:0] r_wdata;
    logic [DATA_W-1:0] r_rd_lo;
    logic [DATA_W-1:0] r_rd_hi;

    logic              split;
    logic [LANES-1:0]  be_lo, be_hi;
    logic [DATA_W-1:0] wd_lo, wd_hi, merged;
    logic [OFF_W-1:0]  word_off;
    logic [MAP_W-1:0]  port;
    logic              accept;

    assign accept = (state == ST_IDLE) && req_valid;

    // Word offset of the transaction being driven
    assign word_off = {r_off[OFF_W-1:LANE_W], {LANE_W{1'b0}}}
                    + ((state == ST_HI_XFER) ? OFF_W'(LANES) : OFF_W'(0));

    io_addr_map #(.OFF_W(OFF_W), .MAP_W(MAP_W)) u_map (
        .sparse (r_sparse),
        .off    (word_off),
        .port   (port)
    );

    io_lane_unit #(.DATA_W(DATA_W)) u_lanes (
        .lane   (r_off[LANE_W-1:0]),
        .size   (r_size),
        .wdata  (r_wdata),
        .rd_lo  (r_rd_lo),
        .rd_hi  (r_rd_hi),
        .split  (split),
        .be_lo  (be_lo),
        .be_hi  (be_hi),
        .wd_lo  (wd_lo),
        .wd_hi  (wd_hi),
        .rdata  (merged)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = size_legal(req_size) ? ST_LO_XFER : ST_REPLY;
            ST_LO_XFER: if (dn_ready)  state_nx = split ? ST_HI_XFER : ST_REPLY;
            ST_HI_XFER: if (dn_ready)  state_nx = ST_REPLY;
            ST_REPLY:                  state_nx = ST_IDLE;
        endcase
    end

    // State and capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            r_write  <= 1'b0;
            r_sparse <= 1'b0;
            r_err    <= 1'b0;
            r_off    <= '0;
            r_size   <= '0;
            r_wdata  <= '0;
            r_rd_lo  <= '0;
            r_rd_hi  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                r_write  <= req_write;
                r_sparse <= map_sparse;
                r_err    <= !size_legal(req_size);
                r_off    <= req_addr;
                r_size   <= req_size;
                r_wdata  <= req_wdata;
                r_rd_lo  <= '0;
                r_rd_hi  <= '0;
            end
            if (state == ST_LO_XFER && dn_ready) r_rd_lo <= dn_rdata;
            if (state == ST_HI_XFER && dn_ready) r_rd_hi <= dn_rdata;
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        dn_valid  = (state == ST_LO_XFER) || (state == ST_HI_XFER);
        dn_write  = r_write;
        dn_addr   = BASE + ADDR_W'(port);
        dn_be     = (state == ST_HI_XFER) ? be_hi : be_lo;
        dn_wdata  = (state == ST_HI_XFER) ? wd_hi : wd_lo;
        rsp_valid = (state == ST_REPLY);
        rsp_err   = r_err;
        rsp_rdata = (r_err || r_write) ? '0 : merged;
    end

endmodule

// File: rtl/io_window_xlate_chk.sv
module io_window_xlate_chk
    import io_xlate_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'h8000_0000,
    parameter int          MAP_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [2:0]  req_size,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic        dn_valid,
    input logic        dn_ready,
    input logic        dn_write,
    input logic [31:0] dn_addr,
    input logic [3:0]  dn_be
);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_be) && $stable(dn_write));

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !req_ready);

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !size_legal(req_size) |=> rsp_valid && rsp_err && !dn_valid);

    p_err_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_rdata == 32'h0);

    p_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> dn_be != 4'h0);

    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> (((dn_addr - BASE) >> MAP_W) == 32'h0) && (dn_addr[1:0] == 2'b00));

endmodule

bind io_window_xlate io_window_xlate_chk #(.BASE(BASE), .MAP_W(MAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .dn_valid  (dn_valid),
    .dn_ready  (dn_ready),
    .dn_write  (dn_write),
    .dn_addr   (dn_addr),
    .dn_be     (dn_be)
);

// File: tb/io_window_xlate_bench.sv
module io_window_xlate_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h8000_0000;
    localparam logic [31:0] KEY        = 32'h5AC3_96E1;

    logic        clk;
    logic        rst_n;
    logic        map_sparse;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [22:0] req_addr;
    logic [2:0]  req_size;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        dn_valid;
    logic        dn_ready;
    logic        dn_write;
    logic [31:0] dn_addr;
    logic [3:0]  dn_be;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    int          rec_n = 0;
    bit          stall = 0;
    logic [31:0] rec_addr [4];
    logic [3:0]  rec_be   [4];
    logic [31:0] rec_wd   [4];
    logic        rec_wr   [4];

    io_window_xlate u_io_window_xlate (
        .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    // Downstream responder: read data derived from the address
    assign dn_rdata = dn_addr ^ KEY;

    always @(negedge clk) begin
        dn_ready = stall ? !dn_ready : 1'b1;
        if (dn_valid && dn_ready) begin
            if (rec_n < 4) begin
                rec_addr[rec_n] = dn_addr;
                rec_be[rec_n]   = dn_be;
                rec_wd[rec_n]   = dn_wdata;
                rec_wr[rec_n]   = dn_write;
            end
            rec_n++;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] xl(bit sp, logic [22:0] o);
        return sp ? {o[22:12], o[4:0]} : o[15:0];
    endfunction

    task automatic access(bit wr, logic [22:0] off, logic [2:0] sz, logic [31:0] wd,
                          bit sp, bit flip, string req);
        bit          legal;
        bit          seen;
        int          lane;
        int          nexp;
        logic [22:0] wk;
        logic [15:0] m16;
        logic [31:0] ea  [2];
        logic [3:0]  ebe [2];
        logic [31:0] ewd [2];
        logic [31:0] erd;
        logic [31:0] tmp;
        logic [31:0] got_rd;
        logic        got_err;
        legal = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
        lane  = int'(off[1:0]);
        nexp  = !legal ? 0 : ((lane + int'(sz) > 4) ? 2 : 1);
        erd   = '0;
        got_rd = '0;
        got_err = 1'b0;
        for (int k = 0; k < 2; k++) begin
            wk = {off[22:2], 2'b00} + 23'(4 * k);
            m16 = xl(sp, wk);
            ea[k]  = BASE + {16'h0, m16};
            ebe[k] = '0;
            ewd[k] = '0;
        end
        if (legal) begin
            for (int i = 0; i < int'(sz); i++) begin
                int pos, k, l;
                pos = lane + i;
                k = pos / 4;
                l = pos % 4;
                ebe[k][l] = 1'b1;
                ewd[k][8*l +: 8] = wd[8*i +: 8];
                tmp = ea[k] ^ KEY;
                if (!wr) erd[8*i +: 8] = tmp[8*l +: 8];
            end
        end
        @(negedge clk);
        map_sparse = sp;
        rec_n      = 0;
        req_valid  = 1'b1;
        req_write  = wr;
        req_addr   = off;
        req_size   = sz;
        req_wdata  = wd;
        @(posedge clk);
        #1;
        if (flip) map_sparse = !sp;
        @(negedge clk);
        req_valid = 1'b0;
        if (legal) check("R9", "req_ready while busy", 32'(req_ready), 32'h0);
        seen = 0;
        for (int c = 0; c < 40 && !seen; c++) begin
            if (rsp_valid) begin
                seen    = 1;
                got_rd  = rsp_rdata;
                got_err = rsp_err;
            end else begin
                @(negedge clk);
            end
        end
        check("R9", "response seen", 32'(seen), 32'h1);
        @(negedge clk);
        check("R9", "single response pulse", 32'(rsp_valid), 32'h0);
        check(req, "transaction count", 32'(rec_n), 32'(nexp));
        for (int k = 0; k < nexp && k < rec_n; k++) begin
            check(req, "dn_addr", rec_addr[k], ea[k]);
            check("R4", "dn_be", 32'(rec_be[k]), 32'(ebe[k]));
            check(req, "dn_write", 32'(rec_wr[k]), 32'(wr));
            if (wr) begin
                logic [31:0] lm;
                for (int b = 0; b < 4; b++) lm[8*b +: 8] = {8{ebe[k][b]}};
                check("R4", "dn_wdata lanes", rec_wd[k] & lm, ewd[k]);
            end
        end
        check(legal ? req : "R5", "rsp_err", 32'(got_err), 32'(!legal));
        check(!legal ? "R5" : (wr ? "R10" : "R7"), "rsp_rdata", got_rd, erd);
        map_sparse = sp;
    endtask

    task automatic t_reset_r1();
        check("R1", "req_ready", 32'(req_ready), 32'h1);
        check("R1", "dn_valid", 32'(dn_valid), 32'h0);
        check("R1", "rsp_valid", 32'(rsp_valid), 32'h0);
    endtask

    task automatic t_dense_r2();
        stall = 0;
        access(1'b0, 23'h7F_1234, 3'd4, 32'h0, 1'b0, 1'b0, "R2");
        access(1'b1, 23'h3A_BCD1, 3'd1, 32'h0000_00C7, 1'b0, 1'b0, "R2");
        access(1'b0, 23'h12_0FE2, 3'd2, 32'h0, 1'b0, 1'b0, "R2");
        access(1'b1, 23'h00_0CFC, 3'd4, 32'hDEAD_BEEF, 1'b0, 1'b0, "R2");
    endtask

    task automatic t_sparse_r3();
        stall = 0;
        access(1'b0, 23'h5A_3F9C, 3'd4, 32'h0, 1'b1, 1'b0, "R3");
        access(1'b1, 23'h7F_FFE3, 3'd1, 32'h0000_0055, 1'b1, 1'b0, "R3");
        access(1'b0, 23'h01_2FE2, 3'd2, 32'h0, 1'b1, 1'b0, "R3");
        access(1'b0, 23'h00_0FE0, 3'd1, 32'h0, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_bad_size_r5();
        stall = 0;
        access(1'b0, 23'h00_1000, 3'd0, 32'h0, 1'b0, 1'b0, "R5");
        access(1'b1, 23'h00_1001, 3'd3, 32'h1122_3344, 1'b1, 1'b0, "R5");
        access(1'b0, 23'h00_1002, 3'd5, 32'h0, 1'b0, 1'b0, "R5");
        access(1'b1, 23'h00_1003, 3'd7, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_split_r6();
        stall = 1;
        access(1'b0, 23'h00_2001, 3'd4, 32'h0, 1'b0, 1'b0, "R6");
        access(1'b1, 23'h00_2002, 3'd4, 32'hA1B2_C3D4, 1'b0, 1'b0, "R6");
        access(1'b0, 23'h00_2003, 3'd2, 32'h0, 1'b0, 1'b0, "R6");
        access(1'b0, 23'h00_1FFF, 3'd4, 32'h0, 1'b1, 1'b0, "R6");
        access(1'b1, 23'h4C_301E, 3'd4, 32'h0BAD_F00D, 1'b1, 1'b0, "R6");
        access(1'b0, 23'h7F_FFFF, 3'd2, 32'h0, 1'b0, 1'b0, "R6");
        stall = 0;
    endtask

    task automatic t_merge_r7();
        stall = 1;
        access(1'b0, 23'h00_0043, 3'd4, 32'h0, 1'b1, 1'b0, "R7");
        access(1'b0, 23'h00_0041, 3'd2, 32'h0, 1'b0, 1'b0, "R7");
        stall = 0;
    endtask

    task automatic t_mode_latch_r8();
        stall = 1;
        access(1'b0, 23'h35_6A7D, 3'd4, 32'h0, 1'b0, 1'b1, "R8");
        access(1'b1, 23'h35_6A7E, 3'd4, 32'h7788_99AA, 1'b1, 1'b1, "R8");
        stall = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        map_sparse = 1'b0;
        req_valid  = 1'b0;
        req_write  = 1'b0;
        req_addr   = '0;
        req_size   = '0;
        req_wdata  = '0;
        dn_ready   = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        t_dense_r2();
        t_sparse_r3();
        t_bad_size_r5();
        t_split_r6();
        t_merge_r7();
        t_mode_latch_r8();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule